// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the software-facing register window of a multi-channel event timer. It decodes a 1 KB window that is reached only through aligned 32-bit word accesses on a simple valid/write bus, and it returns read data one cycle after the access. It holds the identification words, the global control word, the 64-bit main counter and one register window per timer channel. Each window has three 64-bit registers (configuration, comparator, routing), each reached as two 32-bit halves.

The main counter advances by one on every clock while the global enable is set and freezes when the enable is clear. It can be loaded half by half by software. Writes to timer windows and to the status register are passed on, one cycle later, as decoded strobes with their data, to the channel logic and to the status logic. When the global enable rises, the block sends a one-cycle arm pulse to every channel whose comparator is not all ones. When the enable falls, it sends a one-cycle disarm pulse to every channel.

Top module: `evt_tmr_regs`

## Requirements
- R1: Word 0x000 reads 0x8086A001 with (timer count minus one) placed in bits 12:8 (0x8086A201 for three timers). Word 0x004 reads the tick period in femtoseconds (parameter, default 10,000,000). Writes to both words are ignored.
- R2: Global control at 0x010. Only bit 0 (enable) and bit 1 (legacy routing) are writable, and they drive `glb_en_o` and `legacy_o`. The other bits read 0. Word 0x014 always reads 0 and ignores writes. The control word resets to 0.
- R3: Main counter halves sit at 0x0F0 (bits 31:0) and 0x0F4 (bits 63:32). Each half can be written on its own without touching the other half, and the counter resets to 0.
- R4: While enabled, the counter rises by exactly one per clock edge, with carry from the low half into the high half. While halted, it holds its value. A read returns the value the counter had in the access cycle.
- R5: A counter half write in a cycle when the counter is enabled takes precedence over that cycle's increment. The written half takes the new data, the other half keeps its value, and counting resumes from the written value on the next edge.
- R6: Timer n's window starts at 0x100 + n*0x20. Offsets +0/+4 are config low/high, +8/+C are comparator low/high, and +10/+14 are route low/high. Offsets +18 and +1C read 0 and produce no strobe.
- R7: A timer config resets to low word 0x00000030 (periodic-capable bit 4, 64-bit-capable bit 5) and high word 0x00000004 (route 2 available). Writes to the low word change only the bits in mask 0x00007F4E. The high word is read-only.
- R8: Comparators reset to all ones, and route registers reset to 0. A config low write with bit 8 (32-bit mode) set clears the comparator's upper half.
- R9: An access to a timer index at or above the timer count reads 0, changes nothing and produces no channel strobe. The count is clamped to 3..32.
- R10: A write into a valid timer window raises bit n of `ch_wr_o` for one cycle in the cycle after the access. In the same cycle, `ch_slot_o` carries the word offset (0..5, in the order of R6) and `wr_data_o` carries the written word.
- R11: A read of 0x020 returns `isr_i`, zero-extended. A write to 0x020 pulses `sts_wr_o` for one cycle in the cycle after the access, with the data on `wr_data_o`.
- R12: In the cycle after a write that sets the enable from 0, `arm_o` has bit n set for each timer whose 64-bit comparator is not all ones. In the cycle after a write that clears the enable from 1, `disarm_o` has all timer bits set. Rewriting the same enable value produces no pulse.
- R13: Read data appears on `bus_rdata_o` in the cycle after the read. Unmapped or non-word-aligned addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Byte address in the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read |
| isr_i | input | NT | Interrupt status from the status logic |
| ch_wr_o | output | NT | One-hot channel write strobe |
| ch_slot_o | output | 3 | Word offset inside the channel window |
| sts_wr_o | output | 1 | Status register write strobe |
| wr_data_o | output | 32 | Data for channel and status strobes |
| arm_o | output | NT | One-cycle arm pulse per channel |
| disarm_o | output | NT | One-cycle disarm pulse per channel |
| glb_en_o | output | 1 | Global enable |
| legacy_o | output | 1 | Legacy routing select |
| count_o | output | 64 | Main counter value |

## Verification
The running increment of the main counter and a software write of one counter half can land on the same clock edge. The bench provokes this by enabling the counter and then writing the low half on the very next access, with no idle cycles in between. It then reads the low half on back-to-back cycles. It expects the written value first, then that value plus one, and after disabling the exact count of the edges that followed. A carry case loads 0xFFFFFFFF into the low half and runs one edge, to judge that the high half picks up the carry.

// File: rtl/evt_pkg.sv
package evt_pkg;

  localparam int WIN_AW = 10;

  localparam logic [WIN_AW-1:0] OFS_CAP_LO  = 10'h000;
  localparam logic [WIN_AW-1:0] OFS_CAP_HI  = 10'h004;
  localparam logic [WIN_AW-1:0] OFS_GCFG    = 10'h010;
  localparam logic [WIN_AW-1:0] OFS_GCFG_HI = 10'h014;
  localparam logic [WIN_AW-1:0] OFS_STS     = 10'h020;
  localparam logic [WIN_AW-1:0] OFS_CNT_LO  = 10'h0F0;
  localparam logic [WIN_AW-1:0] OFS_CNT_HI  = 10'h0F4;

  localparam int TMR_FIRST_BLK = 8;  // 0x100 / 0x20
  localparam int TMR_MAX_WIN   = 24; // blocks 0x100..0x3FF

  localparam logic [31:0] CAP_BASE     = 32'h8086_A001;
  localparam logic [31:0] GCFG_WMASK   = 32'h0000_0003;
  localparam logic [31:0] TCFG_WMASK   = 32'h0000_7F4E;
  localparam logic [31:0] TCFG_RST_LO  = 32'h0000_0030;
  localparam logic [31:0] TCFG_RST_HI  = 32'h0000_0004;
  localparam int          TCFG_BIT_32  = 8;

  typedef enum logic [2:0] {
    SLOT_CFG_LO = 3'd0,
    SLOT_CFG_HI = 3'd1,
    SLOT_CMP_LO = 3'd2,
    SLOT_CMP_HI = 3'd3,
    SLOT_RT_LO  = 3'd4,
    SLOT_RT_HI  = 3'd5
  } slot_e;

  typedef enum logic [3:0] {
    ACC_NONE,
    ACC_CAP_LO,
    ACC_CAP_HI,
    ACC_GCFG,
    ACC_GCFG_HI,
    ACC_STS,
    ACC_CNT_LO,
    ACC_CNT_HI,
    ACC_TMR
  } acc_e;

  typedef struct packed {
    logic       wr;
    logic       rd;
    acc_e       kind;
    logic [4:0] idx;
    slot_e      slot;
  } dec_t;

  function automatic int clamp_nt(input int n);
    if (n < 3)  return 3;
    if (n > 32) return 32;
    return n;
  endfunction

endpackage

// File: rtl/evt_addr_dec.sv
module evt_addr_dec
  import evt_pkg::*;
#(
  parameter int NT = 3
) (
  input  logic              valid_i,
  input  logic              we_i,
  input  logic [WIN_AW-1:0] addr_i,
  output dec_t              dec_o
);

  logic [4:0] blk;
  logic [4:0] tidx;

  assign blk  = addr_i[9:5];
  assign tidx = blk - 5'(TMR_FIRST_BLK);

  always_comb begin
    dec_o.wr   = valid_i && we_i;
    dec_o.rd   = valid_i && !we_i;
    dec_o.kind = ACC_NONE;
    dec_o.idx  = '0;
    dec_o.slot = SLOT_CFG_LO;
    if (addr_i[9:8] != 2'b00) begin
      // timer windows: word aligned, slots 0..5, index below count
      if (addr_i[1:0] == 2'b00 && addr_i[4:2] <= 3'd5 && 32'(tidx) < NT) begin
        dec_o.kind = ACC_TMR;
        dec_o.idx  = tidx;
        dec_o.slot = slot_e'(addr_i[4:2]);
      end
    end else begin
      case (addr_i)
        OFS_CAP_LO:  dec_o.kind = ACC_CAP_LO;
        OFS_CAP_HI:  dec_o.kind = ACC_CAP_HI;
        OFS_GCFG:    dec_o.kind = ACC_GCFG;
        OFS_GCFG_HI: dec_o.kind = ACC_GCFG_HI;
        OFS_STS:     dec_o.kind = ACC_STS;
        OFS_CNT_LO:  dec_o.kind = ACC_CNT_LO;
        OFS_CNT_HI:  dec_o.kind = ACC_CNT_HI;
        default:     dec_o.kind = ACC_NONE;
      endcase
    end
  end

endmodule

// File: rtl/evt_main_cnt.sv
module evt_main_cnt #(
  parameter int CW = 64,
  localparam int HW = CW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [HW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q;

  // software load takes precedence over the running increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_lo_i) begin
      cnt_q <= {cnt_q[CW-1:HW], wdata_i};
    end else if (wr_hi_i) begin
      cnt_q <= {wdata_i, cnt_q[HW-1:0]};
    end else if (en_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/evt_tmr_win.sv
module evt_tmr_win
  import evt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  slot_e       slot_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        armable_o
);

  logic [31:0] cfg_lo_q;
  logic [63:0] cmp_q;
  logic [63:0] rt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_lo_q <= TCFG_RST_LO;
      cmp_q    <= '1;
      rt_q     <= '0;
    end else if (wr_i) begin
      case (slot_i)
        SLOT_CFG_LO: begin
          cfg_lo_q <= (wdata_i & TCFG_WMASK) | (cfg_lo_q & ~TCFG_WMASK);
          if (wdata_i[TCFG_BIT_32]) cmp_q[63:32] <= '0;
        end
        SLOT_CMP_LO: cmp_q[31:0]  <= wdata_i;
        SLOT_CMP_HI: cmp_q[63:32] <= wdata_i;
        SLOT_RT_LO:  rt_q[31:0]   <= wdata_i;
        SLOT_RT_HI:  rt_q[63:32]  <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (slot_i)
      SLOT_CFG_LO: rdata_o = cfg_lo_q;
      SLOT_CFG_HI: rdata_o = TCFG_RST_HI;
      SLOT_CMP_LO: rdata_o = cmp_q[31:0];
      SLOT_CMP_HI: rdata_o = cmp_q[63:32];
      SLOT_RT_LO:  rdata_o = rt_q[31:0];
      SLOT_RT_HI:  rdata_o = rt_q[63:32];
      default:     rdata_o = '0;
    endcase
  end

  assign armable_o = ~&cmp_q;

endmodule

// File: rtl/evt_tmr_regs.sv
module evt_tmr_regs
  import evt_pkg::*;
#(
  parameter int          NUM_TIMERS = 3,
  parameter logic [31:0] TICK_FS    = 32'd10_000_000,
  localparam int         NT         = clamp_nt(NUM_TIMERS),
  localparam int         NWIN       = (NT < TMR_MAX_WIN) ? NT : TMR_MAX_WIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [WIN_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NT-1:0]     isr_i,
  output logic [NT-1:0]     ch_wr_o,
  output logic [2:0]        ch_slot_o,
  output logic              sts_wr_o,
  output logic [31:0]       wr_data_o,
  output logic [NT-1:0]     arm_o,
  output logic [NT-1:0]     disarm_o,
  output logic              glb_en_o,
  output logic              legacy_o,
  output logic [63:0]       count_o
);

  localparam logic [31:0] CAP_WORD = {CAP_BASE[31:13], 5'(NT - 1), CAP_BASE[7:0]};

  dec_t        dec;
  logic [31:0] gcfg_q;
  logic [31:0] rdata_q;
  logic [31:0] rd_mux;
  logic [63:0] cnt;
  logic        en_rise;
  logic        en_fall;

  logic [31:0]   win_rdata [NWIN];
  logic [NWIN-1:0] win_wr;
  logic [NT-1:0]   armable;

  logic [NT-1:0] ch_wr_q;
  logic [2:0]    slot_q;
  logic          sts_wr_q;
  logic [31:0]   wd_q;
  logic [NT-1:0] arm_q;
  logic [NT-1:0] disarm_q;

  evt_addr_dec #(.NT(NT)) u_dec (
    .valid_i (bus_valid_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .dec_o   (dec)
  );

  evt_main_cnt #(.CW(64)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (gcfg_q[0]),
    .wr_lo_i (dec.wr && dec.kind == ACC_CNT_LO),
    .wr_hi_i (dec.wr && dec.kind == ACC_CNT_HI),
    .wdata_i (bus_wdata_i),
    .cnt_o   (cnt)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    assign win_wr[i] = dec.wr && dec.kind == ACC_TMR && dec.idx == 5'(i);
    evt_tmr_win u_win (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (win_wr[i]),
      .slot_i    (dec.slot),
      .wdata_i   (bus_wdata_i),
      .rdata_o   (win_rdata[i]),
      .armable_o (armable[i])
    );
  end

  // timers with no reachable window never hold a usable comparator
  if (NT > NWIN) begin : g_unreach
    assign armable[NT-1:NWIN] = '0;
  end

  assign en_rise = dec.wr && dec.kind == ACC_GCFG &&  bus_wdata_i[0] && !gcfg_q[0];
  assign en_fall = dec.wr && dec.kind == ACC_GCFG && !bus_wdata_i[0] &&  gcfg_q[0];

  always_comb begin
    rd_mux = '0;
    case (dec.kind)
      ACC_CAP_LO:  rd_mux = CAP_WORD;
      ACC_CAP_HI:  rd_mux = TICK_FS;
      ACC_GCFG:    rd_mux = gcfg_q;
      ACC_STS:     rd_mux = 32'(isr_i);
      ACC_CNT_LO:  rd_mux = cnt[31:0];
      ACC_CNT_HI:  rd_mux = cnt[63:32];
      ACC_TMR: begin
        for (int i = 0; i < NWIN; i++) begin
          if (dec.idx == 5'(i)) rd_mux = win_rdata[i];
        end
      end
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gcfg_q   <= '0;
      rdata_q  <= '0;
      ch_wr_q  <= '0;
      slot_q   <= '0;
      sts_wr_q <= 1'b0;
      wd_q     <= '0;
      arm_q    <= '0;
      disarm_q <= '0;
    end else begin
      if (dec.wr && dec.kind == ACC_GCFG) begin
        gcfg_q <= (bus_wdata_i & GCFG_WMASK) | (gcfg_q & ~GCFG_WMASK);
      end
      if (dec.rd) rdata_q <= rd_mux;
      ch_wr_q  <= NT'(win_wr);
      slot_q   <= dec.slot;
      sts_wr_q <= dec.wr && dec.kind == ACC_STS;
      if (dec.wr) wd_q <= bus_wdata_i;
      arm_q    <= en_rise ? armable : '0;
      disarm_q <= en_fall ? '1 : '0;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign ch_wr_o     = ch_wr_q;
  assign ch_slot_o   = slot_q;
  assign sts_wr_o    = sts_wr_q;
  assign wr_data_o   = wd_q;
  assign arm_o       = arm_q;
  assign disarm_o    = disarm_q;
  assign glb_en_o    = gcfg_q[0];
  assign legacy_o    = gcfg_q[1];
  assign count_o     = cnt;

endmodule

// File: rtl/evt_tmr_regs_chk.sv
module evt_tmr_regs_chk #(
  parameter int NT = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_valid_i,
  input logic          bus_we_i,
  input logic [9:0]    bus_addr_i,
  input logic [63:0]   count_o,
  input logic          glb_en_o,
  input logic [NT-1:0] arm_o,
  input logic [NT-1:0] disarm_o,
  input logic [NT-1:0] ch_wr_o,
  input logic          sts_wr_o
);

  logic cnt_wr;
  assign cnt_wr = bus_valid_i && bus_we_i &&
                  (bus_addr_i == 10'h0F0 || bus_addr_i == 10'h0F4);

  p_run_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(glb_en_o) && !$past(cnt_wr)) |-> count_o == $past(count_o) + 64'd1);

  p_halt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(glb_en_o) && !$past(cnt_wr)) |-> count_o == $past(count_o));

  p_arm_on_rise_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|arm_o) |-> $rose(glb_en_o));

  p_disarm_on_fall_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|disarm_o) |-> $fell(glb_en_o));

  p_arm_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|arm_o) && (|disarm_o)));

  p_ch_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o));

  p_sts_alone_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_wr_o |-> ch_wr_o == '0);

endmodule

bind evt_tmr_regs evt_tmr_regs_chk #(.NT(NT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .count_o     (count_o),
  .glb_en_o    (glb_en_o),
  .arm_o       (arm_o),
  .disarm_o    (disarm_o),
  .ch_wr_o     (ch_wr_o),
  .sts_wr_o    (sts_wr_o)
);

// File: tb/evt_tmr_regs_bench.sv
`timescale 1ns/1ps
module evt_tmr_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic        we;
  logic [9:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [2:0]  isr;
  logic [2:0]  ch_wr;
  logic [2:0]  ch_slot;
  logic        sts_wr;
  logic [31:0] wr_data;
  logic [2:0]  arm;
  logic [2:0]  disarm;
  logic        glb_en;
  logic        legacy;
  logic [63:0] count;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] c_rd;
  logic [2:0]  c_chwr, c_slot, c_arm, c_disarm;
  logic        c_sts;
  logic [31:0] c_wd;

  always #2.5 clk = ~clk;

  evt_tmr_regs u_evt_tmr_regs (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_valid_i (valid),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .isr_i       (isr),
    .ch_wr_o     (ch_wr),
    .ch_slot_o   (ch_slot),
    .sts_wr_o    (sts_wr),
    .wr_data_o   (wr_data),
    .arm_o       (arm),
    .disarm_o    (disarm),
    .glb_en_o    (glb_en),
    .legacy_o    (legacy),
    .count_o     (count)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // one access per cycle; called at a falling edge, returns at the next one
  task automatic acc(input logic w, input logic [9:0] a, input logic [31:0] d);
    valid = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    c_rd = rdata; c_chwr = ch_wr; c_slot = ch_slot; c_sts = sts_wr;
    c_wd = wr_data; c_arm = arm; c_disarm = disarm;
  endtask

  task automatic rd(input logic [9:0] a);
    acc(1'b0, a, 32'h0);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic t_reset;
    chk("R2 glb_en reset", glb_en, 0);
    chk("R12 arm reset", arm, 0);
    chk("R3 count reset", count, 0);
    rd(10'h000); chk("R1 cap lo", c_rd, 32'h8086_A201);
    rd(10'h010); chk("R2 gcfg reset", c_rd, 0);
    rd(10'h100); chk("R7 t0 cfg lo reset", c_rd, 32'h30);
    rd(10'h104); chk("R7 t0 cfg hi reset", c_rd, 32'h4);
    rd(10'h128); chk("R8 t1 cmp lo reset", c_rd, 32'hFFFF_FFFF);
    rd(10'h154); chk("R8 t2 route hi reset", c_rd, 0);
  endtask

  task automatic t_cap;
    wr(10'h000, 32'h0);
    rd(10'h000); chk("R1 cap lo ignores write", c_rd, 32'h8086_A201);
    wr(10'h004, 32'h0);
    rd(10'h004); chk("R1 cap hi period", c_rd, 32'd10_000_000);
  endtask

  task automatic t_gcfg;
    wr(10'h010, 32'hFFFF_FFFE);
    rd(10'h010); chk("R2 gcfg mask", c_rd, 32'h2);
    chk("R2 legacy_o", legacy, 1);
    chk("R2 glb_en_o stays 0", glb_en, 0);
    wr(10'h014, 32'hFFFF_FFFF);
    rd(10'h014); chk("R2 gcfg hi reads 0", c_rd, 0);
    rd(10'h010); chk("R2 gcfg hi write ignored", c_rd, 32'h2);
    wr(10'h010, 32'h0);
    chk("R2 legacy cleared", legacy, 0);
  endtask

  task automatic t_cnt_halves;
    wr(10'h0F0, 32'h11);
    wr(10'h0F4, 32'h22);
    rd(10'h0F0); chk("R3 cnt lo", c_rd, 32'h11);
    rd(10'h0F4); chk("R3 cnt hi", c_rd, 32'h22);
    wr(10'h0F4, 32'h33);
    rd(10'h0F0); chk("R3 lo kept after hi write", c_rd, 32'h11);
    rd(10'h0F1); chk("R13 unaligned reads 0", c_rd, 0);
    wr(10'h0F8, 32'h5);
    rd(10'h0F8); chk("R13 unmapped reads 0", c_rd, 0);
  endtask

  task automatic t_cnt_run;
    wr(10'h0F0, 32'd5);
    wr(10'h0F4, 32'd0);
    wr(10'h010, 32'h1);
    rd(10'h0F0); chk("R4 first read after enable", c_rd, 32'd5);
    rd(10'h0F0); chk("R4 one per edge", c_rd, 32'd6);
    wr(10'h010, 32'h0);
    rd(10'h0F0); chk("R4 halted value", c_rd, 32'd8);
    rd(10'h0F0); chk("R4 frozen", c_rd, 32'd8);
    wr(10'h0F0, 32'hFFFF_FFFF);
    wr(10'h0F4, 32'h0);
    wr(10'h010, 32'h1);
    wr(10'h010, 32'h0);
    rd(10'h0F4); chk("R4 carry into hi", c_rd, 32'h1);
    rd(10'h0F0); chk("R4 lo wrapped", c_rd, 32'h0);
  endtask

  task automatic t_cnt_collide;
    wr(10'h0F0, 32'h0);
    wr(10'h0F4, 32'h0);
    wr(10'h010, 32'h1);
    wr(10'h0F0, 32'h100);
    rd(10'h0F0); chk("R5 write wins over increment", c_rd, 32'h100);
    rd(10'h0F0); chk("R5 resumes from written", c_rd, 32'h101);
    wr(10'h010, 32'h0);
    rd(10'h0F0); chk("R5 final count", c_rd, 32'h103);
    rd(10'h0F4); chk("R5 hi untouched", c_rd, 32'h0);
  endtask

  task automatic t_tmr_cfg;
    wr(10'h100, 32'hFFFF_FFFF);
    chk("R10 ch_wr t0", c_chwr, 3'b001);
    chk("R10 slot cfg lo", c_slot, 3'd0);
    chk("R10 wr_data", c_wd, 32'hFFFF_FFFF);
    rd(10'h100); chk("R7 cfg write mask", c_rd, 32'h7F7E);
    wr(10'h104, 32'h0);
    rd(10'h104); chk("R7 cfg hi read-only", c_rd, 32'h4);
    rd(10'h10C); chk("R8 32-bit mode clears cmp hi", c_rd, 32'h0);
    wr(10'h100, 32'h0);
    rd(10'h100); chk("R7 cfg cleared keeps caps", c_rd, 32'h30);
    wr(10'h10C, 32'hFFFF_FFFF);
  endtask

  task automatic t_cmp_route;
    wr(10'h12C, 32'h12);
    chk("R10 ch_wr t1", c_chwr, 3'b010);
    chk("R6 slot cmp hi", c_slot, 3'd3);
    rd(10'h12C); chk("R6 t1 cmp hi", c_rd, 32'h12);
    wr(10'h150, 32'hA5);
    chk("R6 slot route lo t2", c_slot, 3'd4);
    rd(10'h150); chk("R6 t2 route lo", c_rd, 32'hA5);
    wr(10'h118, 32'h77);
    chk("R6 slot 6 no strobe", c_chwr, 3'b000);
    rd(10'h118); chk("R6 slot 6 reads 0", c_rd, 0);
    wr(10'h120, 32'h100);
    rd(10'h12C); chk("R8 t1 cmp hi cleared", c_rd, 0);
    rd(10'h128); chk("R8 t1 cmp lo kept", c_rd, 32'hFFFF_FFFF);
    wr(10'h128, 32'h40);
  endtask

  task automatic t_range;
    wr(10'h160, 32'hFFFF);
    chk("R9 no strobe beyond count", c_chwr, 3'b000);
    rd(10'h160); chk("R9 t3 cfg reads 0", c_rd, 0);
    rd(10'h16C); chk("R9 t3 cmp reads 0", c_rd, 0);
  endtask

  task automatic t_status;
    wr(10'h020, 32'h5);
    chk("R11 sts_wr pulse", c_sts, 1);
    chk("R11 sts data", c_wd, 32'h5);
    chk("R11 no channel strobe", c_chwr, 3'b000);
    rd(10'h020); chk("R11 status read", c_rd, 32'h5);
    chk("R11 sts_wr single cycle", c_sts, 0);
  endtask

  task automatic t_arm;
    wr(10'h010, 32'h1);
    chk("R12 arm on rise", c_arm, 3'b010);
    chk("R12 no disarm on rise", c_disarm, 3'b000);
    chk("R2 glb_en_o set", glb_en, 1);
    wr(10'h010, 32'h1);
    chk("R12 no arm on rewrite", c_arm, 3'b000);
    wr(10'h010, 32'h0);
    chk("R12 disarm all on fall", c_disarm, 3'b111);
    chk("R12 no arm on fall", c_arm, 3'b000);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; valid = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    isr = 3'b101;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap();
    t_gcfg();
    t_cnt_halves();
    t_cnt_run();
    t_cnt_collide();
    t_tmr_cfg();
    t_cmp_route();
    t_range();
    t_status();
    t_arm();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

endmodule